// File: doc/BRIEF.md
# Clocked Synchronous Serial Unit

This block is an 8-bit synchronous serial transceiver behind a small register port. A host programs a control register and a bit-rate divider. It then writes one byte to the shared data register. That write starts a full-duplex transfer: eight bits leave on the serial data output while eight bits arrive on the serial data input. When the transfer ends, a read of the same register returns the received byte.

The transfer clock comes from one of two places. In internal mode, a prescaler and an 8-bit divider generate it from the system clock, and the block drives it out. In external mode, a clock pin is synchronised and its edges drive the transfer. The host can choose the clock polarity, the bit order and the output level between transfers. Pin-function and output-enable outputs let the surrounding pad logic tri-state the data line or return the pins to general-purpose use. The control register is guarded by a one-shot unlock. The control, divider and data registers cannot change while a transfer is running.

Register map (`bus_addr_i`): 0 = data, 1 = unlock, 2 = control, 3 = divider. Control fields: bits[1:0] = source (0 = system clock, 1 = divide-by-8, 2 = divide-by-32, 3 = treated as 2); bit2 = output disable; bit3 = serial pin function; bit4 = idle level; bit5 = polarity; bit6 = internal clock; bit7 = MSB first.

Top module: `sync_serial_unit`

## Requirements
- R1: After reset the control register reads 0x40, the divider reads 0, `busy_o` is 0, `sclk_o` is 1, and `pin_func_o`, `sout_oe_o` and `sclk_oe_o` are 0.
- R2: A write to address 2 is accepted only if the write just before it went to address 1 with bit0 = 1. Any other control write is ignored.
- R3: Writing address 0 while idle starts a transfer. In internal mode, each half period of `sclk_o` lasts (n+1)*P system cycles, where n is the divider value and P is 1, 8 or 32 for source 0, 1 or 2. Successive sample edges are therefore 2*(n+1)*P cycles apart.
- R4: With control bit7 = 0, `sout_o` sends the written byte LSB first. With bit7 = 1, it sends it MSB first.
- R5: With bit5 = 0, `sout_o` changes only on falling transfer-clock edges and `sin_i` is sampled on rising edges. With bit5 = 1, the two edges are swapped. Bit5 acts only while bit3 = 1.
- R6: After completion, address 0 reads the eight sampled bits. The first sampled bit lands in bit0 when LSB first and in bit7 when MSB first.
- R7: `done_o` pulses for exactly one cycle, in the same cycle that `busy_o` falls.
- R8: `sclk_o` is high whenever the unit has been idle for at least one cycle.
- R9: With bit6 = 0, transfers are clocked by `sclk_ext_i` through a synchroniser, and `sclk_oe_o` is 0.
- R10: `pin_func_o` equals bit3. `sout_oe_o` equals bit3 AND NOT bit2. `sclk_oe_o` equals bit3 AND bit6.
- R11: Between transfers, `sout_o` equals bit4. Bit4 changes only through a control write made while the current bit3 is 0.
- R12: While `busy_o` is 1, writes to the data, control and divider registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| sin_i | input | 1 | Serial data in |
| sclk_ext_i | input | 1 | External transfer clock |
| sout_o | output | 1 | Serial data out |
| sout_oe_o | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Internal transfer clock |
| sclk_oe_o | output | 1 | Clock pin output enable |
| pin_func_o | output | 1 | Serial function selected on the pins |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The table-driven transfers cover all four combinations of bit order and polarity, using three clock sources and several divider values. The transmit and receive bytes are asymmetric, so a swapped edge, a reversed bit order or an off-by-one shift each corrupts a different byte. Timing the sample edges separates the prescaler taps from the divider count. An externally clocked transfer shows that the synchroniser path carries the same data. Writes attempted in the middle of a long transfer show that the registers are frozen while busy.

// File: rtl/ssio_pkg.sv
package ssio_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_PROT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  typedef struct packed {
    logic       msb_first;
    logic       int_clk;
    logic       pol;
    logic       init_lvl;
    logic       port_sel;
    logic       out_dis;
    logic [1:0] src;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 8'h40;
endpackage

// File: rtl/ssio_clkgen.sv
module ssio_clkgen #(
  parameter int DIV_W        = 8,
  parameter int PRE_MID_LOG2 = 3,
  parameter int PRE_MAX_LOG2 = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             int_clk_i,
  input  logic             pol_i,
  input  logic             ext_clk_i,
  output logic             sclk_o,
  output logic             samp_o,
  output logic             outp_o
);
  logic [PRE_MAX_LOG2-1:0] pre_q;
  logic [DIV_W-1:0]        div_cnt_q;
  logic                    sclk_q;
  logic [2:0]              ext_q;
  logic                    tick, toggle, rise, fall;

  always_comb begin
    unique case (src_i)
      2'b00:   tick = 1'b1;
      2'b01:   tick = &pre_q[PRE_MID_LOG2-1:0];
      default: tick = &pre_q;
    endcase
  end

  assign toggle = run_i & int_clk_i & tick & (div_cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      div_cnt_q <= '0;
      sclk_q    <= 1'b1;
    end else if (!run_i || !int_clk_i) begin
      pre_q     <= '0;
      div_cnt_q <= '0;
      sclk_q    <= 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) begin
        if (div_cnt_q == div_i) begin
          div_cnt_q <= '0;
          sclk_q    <= ~sclk_q;
        end else begin
          div_cnt_q <= div_cnt_q + 1'b1;
        end
      end
    end
  end

  // two-stage synchroniser plus history bit for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 3'b111;
    else         ext_q <= {ext_q[1:0], ext_clk_i};
  end

  assign rise = int_clk_i ? (toggle & ~sclk_q) : (ext_q[1] & ~ext_q[2]);
  assign fall = int_clk_i ? (toggle &  sclk_q) : (~ext_q[1] & ext_q[2]);

  assign samp_o = pol_i ? fall : rise;
  assign outp_o = pol_i ? rise : fall;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/ssio_shift.sv
module ssio_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              samp_i,
  input  logic              outp_i,
  input  logic              msb_first_i,
  input  logic              sin_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sdo_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rx_q, busy_q, done_q;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] s,
                                                 input logic b, input logic msb);
    return msb ? {s[DATA_W-2:0], b} : {b, s[DATA_W-1:1]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      rx_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sr_q   <= wdata_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (samp_i) begin
          rx_q <= sin_i;
          if (cnt_q == LAST) begin
            sr_q   <= shift_in(sr_q, sin_i, msb_first_i);
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (outp_i && cnt_q != '0) begin
          sr_q <= shift_in(sr_q, rx_q, msb_first_i);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign data_o = sr_q;
  assign sdo_o  = msb_first_i ? sr_q[DATA_W-1] : sr_q[0];
endmodule

// File: rtl/sync_serial_unit.sv
module sync_serial_unit
  import ssio_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DIV_W        = 8,
  parameter int PRE_MID_LOG2 = 3,
  parameter int PRE_MAX_LOG2 = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              sin_i,
  input  logic              sclk_ext_i,
  output logic              sout_o,
  output logic              sout_oe_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              pin_func_o,
  output logic              busy_o,
  output logic              done_o
);
  ctrl_t             ctrl_q, ctrl_wr;
  logic [DIV_W-1:0]  div_q;
  logic              arm_q;
  logic              busy, start, samp, outp, sdo;
  logic [DATA_W-1:0] data;

  assign start = bus_we_i && bus_addr_i == ADDR_DATA && !busy;

  // idle level is locked once the serial pin function is on
  always_comb begin
    ctrl_wr = ctrl_t'(bus_wdata_i[7:0]);
    if (ctrl_q.port_sel) ctrl_wr.init_lvl = ctrl_q.init_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      div_q  <= '0;
      arm_q  <= 1'b0;
    end else if (bus_we_i) begin
      arm_q <= bus_addr_i == ADDR_PROT && bus_wdata_i[0];
      if (bus_addr_i == ADDR_CTRL && arm_q && !busy) ctrl_q <= ctrl_wr;
      if (bus_addr_i == ADDR_DIV && !busy)           div_q  <= bus_wdata_i[DIV_W-1:0];
    end
  end

  ssio_clkgen #(
    .DIV_W(DIV_W), .PRE_MID_LOG2(PRE_MID_LOG2), .PRE_MAX_LOG2(PRE_MAX_LOG2)
  ) u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .src_i     (ctrl_q.src),
    .div_i     (div_q),
    .int_clk_i (ctrl_q.int_clk),
    .pol_i     (ctrl_q.pol & ctrl_q.port_sel),
    .ext_clk_i (sclk_ext_i),
    .sclk_o    (sclk_o),
    .samp_o    (samp),
    .outp_o    (outp)
  );

  ssio_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .wdata_i     (bus_wdata_i),
    .samp_i      (samp),
    .outp_i      (outp),
    .msb_first_i (ctrl_q.msb_first),
    .sin_i       (sin_i),
    .busy_o      (busy),
    .done_o      (done_o),
    .sdo_o       (sdo),
    .data_o      (data)
  );

  always_comb begin
    unique case (bus_addr_i)
      ADDR_DATA: bus_rdata_o = data;
      ADDR_PROT: bus_rdata_o = DATA_W'(arm_q);
      ADDR_CTRL: bus_rdata_o = DATA_W'(ctrl_q);
      default:   bus_rdata_o = DATA_W'(div_q);
    endcase
  end

  assign busy_o     = busy;
  assign sout_o     = busy ? sdo : ctrl_q.init_lvl;
  assign pin_func_o = ctrl_q.port_sel;
  assign sout_oe_o  = ctrl_q.port_sel & ~ctrl_q.out_dis;
  assign sclk_oe_o  = ctrl_q.port_sel & ctrl_q.int_clk;
endmodule

// File: rtl/ssio_checker.sv
module ssio_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       done_i,
  input logic       sclk_i,
  input logic       sout_oe_i,
  input logic       sclk_oe_i,
  input logic       pin_func_i,
  input logic [7:0] ctrl_i
);
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  assert_done_on_busy_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);
  assert_done_not_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);
  assert_sclk_idle_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $past(!busy_i)) |-> sclk_i);
  assert_ctrl_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(ctrl_i));
  assert_oe_needs_func_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sout_oe_i || sclk_oe_i) |-> pin_func_i);
endmodule

bind sync_serial_unit ssio_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .sclk_i     (sclk_o),
  .sout_oe_i  (sout_oe_o),
  .sclk_oe_i  (sclk_oe_o),
  .pin_func_i (pin_func_o),
  .ctrl_i     (ctrl_q)
);

// File: tb/sync_serial_unit_bench.sv
`timescale 1ns/1ps
module sync_serial_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       sin, sclk_ext = 1'b1;
  logic       sout, sout_oe, sclk, sclk_oe, pin_func, busy, done;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // monitor / slave model state
  logic       ext_mode = 1'b0, mon_msb = 1'b0, mon_pol = 1'b0, mon_en = 1'b0, mon_clr = 1'b0;
  logic [7:0] slave_byte = '0, mon_byte;
  int         mon_k, out_idx;
  time        t_first, t_last;
  wire        mon_clk = ext_mode ? sclk_ext : sclk;

  // {ctrl, divider, tx byte, slave byte}
  localparam logic [31:0] VEC [4] = '{
    32'h48_00_1E_3A,  // LSB, pol0, src0
    32'hC8_02_1E_3A,  // MSB, pol0, src0
    32'h69_01_01_80,  // LSB, pol1, src1
    32'hEA_00_F0_0F   // MSB, pol1, src2
  };

  sync_serial_unit u_sync_serial_unit (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
    .bus_rdata_o(rdata), .sin_i(sin), .sclk_ext_i(sclk_ext), .sout_o(sout),
    .sout_oe_o(sout_oe), .sclk_o(sclk), .sclk_oe_o(sclk_oe), .pin_func_o(pin_func),
    .busy_o(busy), .done_o(done)
  );

  always #2 clk = ~clk;

  assign sin = mon_msb ? slave_byte[7 - (out_idx & 7)] : slave_byte[out_idx & 7];

  always @(mon_clk, posedge mon_clr) begin
    if (mon_clr) begin
      mon_k = 0; out_idx = 0; mon_byte = '0;
    end else if (mon_en && mon_k < 8) begin
      if (mon_clk == ~mon_pol) begin
        if (mon_msb) mon_byte[7 - mon_k] = sout;
        else         mon_byte[mon_k] = sout;
        if (mon_k == 0) t_first = $time;
        if (mon_k == 7) t_last = $time;
        mon_k = mon_k + 1;
      end else if (mon_k > 0) begin
        out_idx = mon_k;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected<150000", cyc);
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we = 1'b0; #1 d = rdata;
  endtask

  task automatic set_ctrl(input logic [7:0] c);
    wr(2'd1, 8'h01); wr(2'd2, c);
  endtask

  task automatic arm_mon(input logic msb, input logic pol, input logic [7:0] slv);
    mon_msb = msb; mon_pol = pol; slave_byte = slv; mon_en = 1'b1;
    mon_clr = 1'b1; #1 mon_clr = 1'b0;
  endtask

  task automatic wait_done();
    int i = 0;
    while (!done && i < 20000) begin @(negedge clk); i++; end
    check("R7 done pulse seen", done, 1'b1);
    check("R7 busy low with done", busy, 1'b0);
    @(negedge clk);
    check("R7 done lasts one cycle", done, 1'b0);
    mon_en = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd2, d); check("R1 ctrl reset", d, 8'h40);
    rd(2'd3, d); check("R1 div reset", d, 8'h00);
    check("R1 busy reset", busy, 1'b0);
    check("R1 R8 sclk idle high", sclk, 1'b1);
    check("R1 enables off", {pin_func, sout_oe, sclk_oe}, 3'b000);

    // R2 protect
    wr(2'd2, 8'h48); rd(2'd2, d); check("R2 unarmed write ignored", d, 8'h40);
    wr(2'd1, 8'h01); wr(2'd3, 8'h00); wr(2'd2, 8'h48);
    rd(2'd2, d); check("R2 intervening write disarms", d, 8'h40);

    // R11 idle level
    set_ctrl(8'h50); check("R11 idle level high", sout, 1'b1);
    check("R10 port off oe", {pin_func, sout_oe}, 2'b00);
    set_ctrl(8'h48); check("R11 idle level low", sout, 1'b0);
    check("R10 oe on", {pin_func, sout_oe, sclk_oe}, 3'b111);
    set_ctrl(8'h58); rd(2'd2, d); check("R11 init locked with port on", d, 8'h48);
    check("R11 sout stays low", sout, 1'b0);

    // R10 output disable, R9 ext clock disables clock drive
    set_ctrl(8'h4C); check("R10 disable tri-states data", {pin_func, sout_oe, sclk_oe}, 3'b101);
    set_ctrl(8'h08); check("R9 R10 ext mode no clock drive", {pin_func, sout_oe, sclk_oe}, 3'b110);

    // table walk: R3 R4 R5 R6 R8
    for (int v = 0; v < 4; v++) begin
      logic [7:0] c, n, tx, sl;
      int p;
      {c, n, tx, sl} = VEC[v];
      set_ctrl(c); wr(2'd3, n);
      arm_mon(c[7], c[5], sl);
      wr(2'd0, tx);
      check("R3 busy after start", busy, 1'b1);
      wait_done();
      check($sformatf("R4 R5 tx order vec%0d", v), mon_byte, tx);
      rd(2'd0, d); check($sformatf("R5 R6 rx byte vec%0d", v), d, sl);
      p = (c[1:0] == 2'd0) ? 1 : (c[1:0] == 2'd1) ? 8 : 32;
      check($sformatf("R3 bit period vec%0d", v), 32'(t_last - t_first), 32'(7 * 2 * (n + 1) * p * 4));
      check("R8 sclk back high", sclk, 1'b1);
      check("R11 sout back to idle", sout, c[4]);
    end

    // R12 writes ignored while busy
    set_ctrl(8'h4A); wr(2'd3, 8'h03);
    arm_mon(1'b0, 1'b0, 8'h33);
    wr(2'd0, 8'h5C);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h01); wr(2'd2, 8'h00); wr(2'd3, 8'h09);
    rd(2'd2, d); check("R12 ctrl frozen", d, 8'h4A);
    rd(2'd3, d); check("R12 div frozen", d, 8'h03);
    check("R12 still busy", busy, 1'b1);
    wait_done();
    check("R12 data write ignored tx", mon_byte, 8'h5C);
    rd(2'd0, d); check("R12 R6 rx after busy writes", d, 8'h33);

    // R9 external clock
    set_ctrl(8'h08);
    ext_mode = 1'b1;
    arm_mon(1'b0, 1'b0, 8'h94);
    wr(2'd0, 8'h6B);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      sclk_ext = 1'b0; repeat (8) @(negedge clk);
      sclk_ext = 1'b1; if (k < 7) repeat (8) @(negedge clk);
    end
    wait_done();
    check("R9 ext tx byte", mon_byte, 8'h6B);
    rd(2'd0, d); check("R9 ext rx byte", d, 8'h94);
    check("R9 internal clock idle", sclk, 1'b1);

    summary();
  end
endmodule